// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C bus master read and write a small internal byte register file. A fast system clock oversamples SCL and SDA through two-flop synchronizers. The block finds START, repeated START and STOP conditions on the synchronized samples. It matches one fixed 7-bit device address and answers only to that address. The block never drives a line high: it pulls SDA low by raising `sda_oe`, and an external pull-up or pad supplies the high level.

A write transfer has three parts: the device address with R/W low, a pointer byte, and then any number of data bytes. The first data byte goes to the register the pointer names. Each further byte first advances the pointer and then writes the next register. A read transfer first sets the pointer in the same way. The master then sends a repeated START and the device address with R/W high, and the slave returns register contents MSB first. A master acknowledge advances the pointer and fetches the next byte. A master not-acknowledge makes the slave release the bus. Every register write is also shown to the user side as a one-cycle strobe with its index and data.

The controller is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: receiving the address byte.
- `ST_PTR`: receiving the pointer byte.
- `ST_WDATA`: receiving a data byte.
- `ST_ACK`: the slave is driving its acknowledge bit.
- `ST_TX`: the slave is shifting out a read byte.
- `ST_MACK`: the slave is waiting for the master's acknowledge.
- `ST_IGNORE`: the slave is released and waits for the next bus condition.

It has these transitions:
- Any state to `ST_ADDR` on START.
- Any state to `ST_IDLE` on STOP.
- `ST_ADDR` to `ST_ACK` on an address match, or to `ST_IGNORE` on a mismatch.
- `ST_PTR` or `ST_WDATA` to `ST_ACK` after eight bits.
- `ST_ACK` to `ST_PTR`, `ST_WDATA` or `ST_TX` at the end of the acknowledge clock.
- `ST_TX` to `ST_MACK` after eight bits.
- `ST_MACK` to `ST_TX` on a master ACK, or to `ST_IGNORE` on a NACK.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, `sda_oe` and `wr_stb` are low and every register reads as 0x00.
- R2: A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released. A START or repeated START (SDA falls while SCL is high) restarts address reception, even in the middle of a byte.
- R3: A first byte whose upper seven bits are 7'b1100100 is acknowledged, with either value of the R/W bit (bit 0, where 0 means write and 1 means read). The slave acknowledges by holding `sda_oe` high through the ninth SCL clock.
- R4: After a non-matching address, the slave does not acknowledge any byte, never asserts `sda_oe`, and writes no register until the next START.
- R5: In a write transfer, the byte after the address is loaded into the pointer (its low log2(REG_COUNT) bits) and is acknowledged.
- R6: The first data byte is written at the pointer. Each later byte in the same transfer increments the pointer and is written there. Every data byte is acknowledged. Each write pulses `wr_stb` for one clock with `wr_idx` and `wr_data`. After a single-byte write, the pointer still names the register that was written.
- R7: After an address with R/W=1, the slave sends the register at the pointer, MSB first, on eight SCL clocks. It then releases SDA for the master's acknowledge bit.
- R8: A master ACK (SDA low on the ninth clock) increments the pointer, and the slave sends the next register. A NACK leaves SDA released until START or STOP, and the pointer stays on the last register read.
- R9: The pointer wraps from REG_COUNT-1 to 0 on both writes and reads. REG_COUNT must be a power of two.
- R10: `sda_oe` changes only while SCL is low. It is set only in the clock after a synchronized SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_stb | output | 1 | One-clock pulse per register write |
| wr_idx | output | PTR_W | Index of the written register |
| wr_data | output | 8 | Byte written |

## Verification
The assertions check on every cycle that the output enable rises only after a sampled SCL falling edge. They also check that STOP and START force the idle and address-reception states, that the ignore and master-acknowledge states keep SDA released, and that the write strobe lasts one clock. Other behaviour shows only in the bench's bus scenarios. This covers pointer loading, increments and wrap on bursts in both directions, and the pointer left behind by a single write or a NACKed read. It also covers silence toward a foreign address and recovery from a START in the middle of a byte. A scoreboard compares every strobed write with the bench's model of the register file.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_prev  <= scl_chain[SYNC_STAGES-1];
            sda_prev  <= sda_chain[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_chain[SYNC_STAGES-1];
    assign sda_s     = sda_chain[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
    parameter int REG_COUNT = 16,
    parameter int PTR_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [7:0]       wdat,
    input  logic [PTR_W-1:0] ridx,
    output logic [7:0]       rdat
);

    logic [7:0] mem [REG_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we) begin
            mem[widx] <= wdat;
        end
    end

    assign rdat = mem[ridx];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100100,
    parameter int         REG_COUNT   = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             wr_stb,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);

    localparam logic [2:0] LAST_BIT = 3'd7;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slv_state_e       state, state_n, after_ack;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] rd_idx;
    logic [7:0]       rd_dat;
    logic [7:0]       rx_byte;
    logic             first_wr;
    logic             mack_ok;
    logic             byte_done;

    assign ptr_inc   = ptr + 1'b1;
    assign rx_byte   = {shreg[6:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt == LAST_BIT);
    assign rd_idx    = (state == ST_MACK) ? ptr_inc : ptr;

    i2c_regbank #(.REG_COUNT(REG_COUNT), .PTR_W(PTR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb),
        .widx  (wr_idx),
        .wdat  (wr_data),
        .ridx  (rd_idx),
        .rdat  (rd_dat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:   state_n = ST_IDLE;
                ST_ADDR:   if (byte_done)
                               state_n = (rx_byte[7:1] == DEV_ADDR) ? ST_ACK : ST_IGNORE;
                ST_PTR,
                ST_WDATA:  if (byte_done) state_n = ST_ACK;
                ST_ACK:    if (scl_fall && sda_oe) state_n = after_ack;
                ST_TX:     if (scl_fall && bit_cnt == LAST_BIT) state_n = ST_MACK;
                ST_MACK:   if (scl_fall) state_n = mack_ok ? ST_TX : ST_IGNORE;
                ST_IGNORE: state_n = ST_IGNORE;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            first_wr  <= 1'b0;
            mack_ok   <= 1'b0;
            after_ack <= ST_IDLE;
        end else begin
            wr_stb <= 1'b0;
            if (stop_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (start_det) begin
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                first_wr <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_done) begin
                            if (state == ST_ADDR) begin
                                after_ack <= rx_byte[0] ? ST_TX : ST_PTR;
                            end else if (state == ST_PTR) begin
                                ptr       <= rx_byte[PTR_W-1:0];
                                first_wr  <= 1'b1;
                                after_ack <= ST_WDATA;
                            end else begin
                                wr_stb    <= 1'b1;
                                wr_idx    <= first_wr ? ptr : ptr_inc;
                                ptr       <= first_wr ? ptr : ptr_inc;
                                wr_data   <= rx_byte;
                                first_wr  <= 1'b0;
                                after_ack <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!sda_oe) begin
                                sda_oe <= 1'b1;
                            end else begin
                                bit_cnt <= '0;
                                if (after_ack == ST_TX) begin
                                    txreg  <= rd_dat;
                                    sda_oe <= ~rd_dat[7];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                txreg   <= {txreg[6:0], 1'b0};
                                sda_oe  <= ~txreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                        if (scl_fall && mack_ok) begin
                            ptr     <= ptr_inc;
                            txreg   <= rd_dat;
                            sda_oe  <= ~rd_dat[7];
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: sda_oe <= 1'b0;
                    default:            sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R10: the drive enable is raised only right after a sampled SCL fall
    a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$past(sda_oe)) |-> $past(scl_fall));

    // R2: STOP returns to idle with the line released
    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R2: START restarts address reception
    a_r2_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR && !sda_oe));

    // R4: a foreign address never drives the bus nor writes
    a_r4_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !wr_stb));

    // R8: SDA is free while the master acknowledges
    a_r8_mack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_oe);

    // R6: each write strobe lasts a single clock
    a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;

    localparam int  REGS  = 16;
    localparam int  Q     = 10;
    localparam logic [6:0] ADDR = 7'b1100100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, wr_stb;
    logic [3:0] wr_idx;
    logic [7:0] wr_data;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regslave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    bit         done = 1'b0;
    logic [7:0] model [REGS];
    logic [11:0] exp_q [$];
    int         oe_hi_viol = 0;
    int         oe_seen = 0;
    logic       scl_q = 1'b1;
    logic       oe_q = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for register writes (R6)
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R4 unexpected write", {wr_idx, wr_data}, 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check({wr_idx, wr_data} == e, "R6 write idx/data", {wr_idx, wr_data}, e);
            end
        end
    end

    // R10 observer: enable must hold while SCL stays high
    always @(negedge clk) begin
        if (rst_n && m_scl && scl_q && sda_oe != oe_q) oe_hi_viol++;
        if (sda_oe) oe_seen++;
        scl_q <= m_scl;
        oe_q  <= sda_oe;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic v, output logic s);
        m_sda = v;
        waitq(Q);
        m_scl = 1'b1;
        waitq(Q);
        s = sda_line;
        waitq(Q);
        m_scl = 1'b0;
        waitq(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        waitq(Q);
        m_scl = 1'b1;
        waitq(Q);
        m_sda = 1'b0;
        waitq(Q);
        m_scl = 1'b0;
        waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        waitq(Q);
        m_scl = 1'b1;
        waitq(Q);
        m_sda = 1'b1;
        waitq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic write_regs(input int p, input logic [7:0] d [], input string tag);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R3 write address ack", ack, 1);
        send_byte(8'(p), ack);
        check(ack, "R5 pointer byte ack", ack, 1);
        for (int k = 0; k < d.size(); k++) begin
            int idx;
            idx = (p + k) % REGS;
            exp_q.push_back({4'(idx), d[k]});
            model[idx] = d[k];
            send_byte(d[k], ack);
            check(ack, tag, ack, 1);
        end
        bus_stop();
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic read_body(input int p, input int n, input string tag);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = (p + k) % REGS;
            recv_byte(k != n - 1, b);
            check(b == model[idx], tag, b, model[idx]);
        end
    endtask

    task automatic read_regs(input int p, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R3 address ack", ack, 1);
        send_byte(8'(p), ack);
        check(ack, "R5 pointer ack", ack, 1);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check(ack, "R3 read address ack", ack, 1);
        read_body(p, n, tag);
        check(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic read_cur(input int p, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check(ack, "R3 read address ack", ack, 1);
        read_body(p, n, tag);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic s;
        for (int i = 0; i < REGS; i++) model[i] = 8'h00;
        waitq(5);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        check(wr_stb == 1'b0, "R1 reset wr_stb", wr_stb, 0);
        rst_n = 1'b1;
        waitq(5);

        read_regs(0, 4, "R1 reset contents");

        write_regs(2, '{8'hF0, 8'h01}, "R6 burst write");
        read_regs(2, 2, "R7 R8 burst read");

        write_regs(5, '{8'hA5}, "R6 single write");
        read_cur(5, 1, "R6 pointer kept after single write");

        write_regs(14, '{8'h11, 8'h22, 8'h33, 8'h44}, "R9 write wrap");
        read_regs(15, 3, "R9 read wrap");

        read_regs(13, 4, "R8 ack burst");
        read_cur(0, 1, "R8 pointer on last byte after NACK");

        // R4: foreign address
        oe_seen = 0;
        bus_start();
        send_byte({7'b1100101, 1'b0}, ack);
        check(!ack, "R4 foreign address nack", ack, 0);
        send_byte(8'h03, ack);
        check(!ack, "R4 pointer ignored", ack, 0);
        send_byte(8'h5A, ack);
        check(!ack, "R4 data ignored", ack, 0);
        bus_stop();
        check(oe_seen == 0, "R4 no drive", oe_seen, 0);
        read_regs(3, 1, "R4 register unchanged");

        // R2: START in the middle of a byte
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        clk_bit(1'b1, s);
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R2 address after mid-byte START", ack, 1);
        send_byte(8'h07, ack);
        check(ack, "R2 pointer after restart", ack, 1);
        exp_q.push_back({4'd7, 8'h3C});
        model[7] = 8'h3C;
        send_byte(8'h3C, ack);
        check(ack, "R2 data after restart", ack, 1);
        bus_stop();
        check(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);
        read_regs(7, 1, "R2 restart write landed");

        check(oe_hi_viol == 0, "R10 enable stable while SCL high", oe_hi_viol, 0);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule